// File: doc/BRIEF.md
# Lane Wander Absorbing FIFO Bank

This block sits between a set of independently timed input lanes and a fixed bit multiplexer that needs every lane in lockstep. Each lane writes words under its own valid strobe, and those strobes may drift earlier or later than the other lanes over time. The read side is common to all lanes. One read enable removes one word from every lane in the same cycle. The block does not adapt the rate: over the long run the lanes write exactly as many words as are read. It must never lose or repeat a word, because the multiplexer gives each word a fixed slot.

After reset, or after a realign, every lane FIFO fills up to half of its configured depth. Reading starts in one cycle for all lanes, and only after the last lane has reached that level. This half-full starting point fixes the latency of the path. It also leaves equal headroom for a lane to run ahead or fall behind. A mode input picks a deep setting (32 words, start at 16) for tolerance or a shallow setting (8 words, start at 4) for low delay. The mode is captured only at a realign.

Any lane that runs dry while reads are active, or is written while full, raises a sticky slip error and freezes the bank. Only a reset or a realign clears it. Fixed skew between lanes is not corrected here; only the variation around the starting alignment is absorbed.

Top module: `lane_wander_fifo_bank`

## Requirements
- R1: After reset, running_o, slip_err_o and rd_valid_o are 0, every lane fill in fill_o is 0, and the deep mode is selected.
- R2: Reading starts together on all lanes. running_o rises on the clock edge after the one at which every lane's fill is at least the prefill target. Before that, rd_en_i has no effect, and a single lane below target holds all lanes back.
- R3: While running, a cycle with rd_en_i high and no empty lane asserts rd_valid_o. In that cycle every lane pops one word. rd_data_o shows each lane's oldest word, in write order, with no word dropped or repeated. Lane k uses bits [k*DATA_W +: DATA_W] of wr_data_i and rd_data_o.
- R4: Lanes may write in different cycles from each other. No error occurs as long as each lane's fill stays between 1 and its depth at every read, and word order on each lane is preserved.
- R5: A cycle with rd_en_i high while running and any lane empty pops nothing and has rd_valid_o low. From the next edge on, slip_err_o is 1 and running_o is 0.
- R6: A write to a lane already holding the full depth, with no pop in the same cycle, is discarded. That lane's fill stays at the depth, and slip_err_o rises at that edge.
- R7: While slip_err_o is 1 and no realign is requested, writes and rd_en_i are ignored: fill_o stays unchanged, rd_valid_o stays 0 and slip_err_o stays 1.
- R8: A cycle with realign_i high empties every lane (fill 0), clears slip_err_o, drops running_o and restarts the prefill. Writes in that cycle are dropped.
- R9: shallow_i is sampled only at a realign. A value of 1 selects depth 8 with prefill target 4, and 0 selects depth 32 with target 16. Changes to shallow_i at any other time have no effect.
- R10: fill_o gives the current word count of lane k in bits [k*6 +: 6], updated at the edge following each write or pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock shared by writes and reads |
| rst_ni | input | 1 | Active-low asynchronous reset |
| realign_i | input | 1 | Flush all lanes, capture mode, restart prefill |
| shallow_i | input | 1 | Mode captured at realign: 1 shallow, 0 deep |
| wr_valid_i | input | N_LANES | Per-lane write strobe |
| wr_data_i | input | N_LANES*DATA_W | Per-lane write words, lane k at [k*DATA_W +: DATA_W] |
| rd_en_i | input | 1 | Common read enable |
| rd_data_o | output | N_LANES*DATA_W | Per-lane head words |
| rd_valid_o | output | 1 | A lockstep pop happens this cycle |
| running_o | output | 1 | Prefill done, reading allowed |
| slip_err_o | output | 1 | Sticky underflow/overflow flag |
| fill_o | output | N_LANES*6 | Per-lane word count |

## Verification
The bench writes the lanes with staggered starts so that the lane that arrives last decides when reading starts. A start triggered by the first lane, or by any lane alone, would raise running_o several cycles early. It makes one lane lag and another lead while reads go on, and compares every popped word with a per-lane sequence number; a pointer that wraps at the wrong depth, or a pop gated per lane, would show up as a repeated or skipped word. It drives a lane dry and a lane past full, then holds writes and reads during the error, so that a non-sticky flag or a leaky freeze would change fill_o. It also toggles the mode input outside a realign: a design that obeys it at once would move the overflow point or the start level.

// File: rtl/lwf_pkg.sv
package lwf_pkg;
  typedef enum logic [1:0] {
    ST_FILL = 2'd0,
    ST_RUN  = 2'd1,
    ST_SLIP = 2'd2
  } lwf_state_e;
endpackage

// File: rtl/lwf_lane_fifo.sv
module lwf_lane_fifo #(
  parameter int DATA_W        = 16,
  parameter int DEPTH_DEEP    = 32,
  parameter int DEPTH_SHALLOW = 8,
  localparam int PTR_W = $clog2(DEPTH_DEEP),
  localparam int CNT_W = $clog2(DEPTH_DEEP + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              shallow_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              empty_o,
  output logic              full_o
);
  logic [DATA_W-1:0] mem_q [DEPTH_DEEP];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q, ptr_lim;
  logic [CNT_W-1:0]  count_q, depth_eff;

  // pointers wrap at the active depth so shallow mode uses the low slots only
  assign ptr_lim   = shallow_i ? PTR_W'(DEPTH_SHALLOW - 1) : PTR_W'(DEPTH_DEEP - 1);
  assign depth_eff = shallow_i ? CNT_W'(DEPTH_SHALLOW) : CNT_W'(DEPTH_DEEP);

  assign data_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;
  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == depth_eff);

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= (wr_ptr_q == ptr_lim) ? '0 : wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= (rd_ptr_q == ptr_lim) ? '0 : rd_ptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  p_no_pop_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_no_push_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o) |-> pop_i);
  p_count_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= depth_eff);
endmodule

// File: rtl/lwf_ctrl.sv
module lwf_ctrl
  import lwf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       realign_i,
  input  logic       shallow_i,
  input  logic       all_ready_i,
  input  logic       overflow_i,
  input  logic       underflow_i,
  output lwf_state_e state_o,
  output logic       shallow_o
);
  lwf_state_e state_q, state_d;
  logic       shallow_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_FILL: if (overflow_i) state_d = ST_SLIP;
               else if (all_ready_i) state_d = ST_RUN;
      ST_RUN:  if (overflow_i || underflow_i) state_d = ST_SLIP;
      ST_SLIP: state_d = ST_SLIP;
      default: state_d = ST_FILL;
    endcase
    if (realign_i) state_d = ST_FILL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_FILL;
      shallow_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (realign_i) shallow_q <= shallow_i;
    end
  end

  assign state_o   = state_q;
  assign shallow_o = shallow_q;

  p_slip_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLIP && !realign_i) |=> state_q == ST_SLIP);
  p_start_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL && !all_ready_i) |=> state_q != ST_RUN);
  p_mode_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !realign_i |=> $stable(shallow_q));
  p_realign_fill_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    realign_i |=> state_q == ST_FILL);
endmodule

// File: rtl/lane_wander_fifo_bank.sv
module lane_wander_fifo_bank
  import lwf_pkg::*;
#(
  parameter int N_LANES       = 10,
  parameter int DATA_W        = 16,
  parameter int DEPTH_DEEP    = 32,
  parameter int DEPTH_SHALLOW = 8,
  localparam int CNT_W = $clog2(DEPTH_DEEP + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      realign_i,
  input  logic                      shallow_i,
  input  logic [N_LANES-1:0]        wr_valid_i,
  input  logic [N_LANES*DATA_W-1:0] wr_data_i,
  input  logic                      rd_en_i,
  output logic [N_LANES*DATA_W-1:0] rd_data_o,
  output logic                      rd_valid_o,
  output logic                      running_o,
  output logic                      slip_err_o,
  output logic [N_LANES*CNT_W-1:0]  fill_o
);
  localparam int TGT_DEEP    = DEPTH_DEEP / 2;
  localparam int TGT_SHALLOW = DEPTH_SHALLOW / 2;

  lwf_state_e         state;
  logic               mode_shallow;
  logic [CNT_W-1:0]   target;
  logic [N_LANES-1:0] empty, full, ready, push, ovf;
  logic               accept, pop, any_empty, underflow;

  assign running_o  = (state == ST_RUN);
  assign slip_err_o = (state == ST_SLIP);
  assign target     = mode_shallow ? CNT_W'(TGT_SHALLOW) : CNT_W'(TGT_DEEP);
  assign accept     = !slip_err_o && !realign_i;
  assign any_empty  = |empty;
  // lockstep pop: either every lane gives a word or none does
  assign pop        = running_o && rd_en_i && !any_empty && !realign_i;
  assign underflow  = running_o && rd_en_i && any_empty;
  assign rd_valid_o = pop;

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    logic [CNT_W-1:0] cnt;
    assign push[k]  = wr_valid_i[k] && accept && (!full[k] || pop);
    assign ovf[k]   = wr_valid_i[k] && accept && full[k] && !pop;
    assign ready[k] = (cnt >= target);
    assign fill_o[k*CNT_W +: CNT_W] = cnt;

    lwf_lane_fifo #(
      .DATA_W       (DATA_W),
      .DEPTH_DEEP   (DEPTH_DEEP),
      .DEPTH_SHALLOW(DEPTH_SHALLOW)
    ) i_fifo (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .flush_i  (realign_i),
      .shallow_i(mode_shallow),
      .push_i   (push[k]),
      .pop_i    (pop),
      .data_i   (wr_data_i[k*DATA_W +: DATA_W]),
      .data_o   (rd_data_o[k*DATA_W +: DATA_W]),
      .count_o  (cnt),
      .empty_o  (empty[k]),
      .full_o   (full[k])
    );
  end

  lwf_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .realign_i  (realign_i),
    .shallow_i  (shallow_i),
    .all_ready_i(&ready),
    .overflow_i (|ovf),
    .underflow_i(underflow),
    .state_o    (state),
    .shallow_o  (mode_shallow)
  );

  p_slip_no_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_err_o |-> !rd_valid_o);
  p_fill_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slip_err_o && !realign_i) |=> $stable(fill_o));
  p_flush_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    realign_i |=> (fill_o == '0 && !slip_err_o && !running_o));
  p_underflow_trips_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underflow && !realign_i) |=> slip_err_o);
endmodule

// File: tb/test_lane_wander_fifo_bank.sv
`timescale 1ns/1ps
module test_lane_wander_fifo_bank;
  localparam int N = 10;
  localparam int W = 16;
  localparam int CW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic realign = 1'b0, shallow = 1'b0, rd_en = 1'b0;
  logic [N-1:0]   wr_valid = '0;
  logic [N*W-1:0] wr_data = '0;
  logic [N*W-1:0] rd_data;
  logic [N*CW-1:0] fill;
  logic rd_valid, running, slip;

  int n_chk = 0, n_fail = 0;
  int wr_seq [N];
  int rd_seq [N];
  bit done = 1'b0;

  always #10 clk = ~clk;

  lane_wander_fifo_bank i_lane_wander_fifo_bank (
    .clk_i(clk), .rst_ni(rst_n), .realign_i(realign), .shallow_i(shallow),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .running_o(running),
    .slip_err_o(slip), .fill_o(fill)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lane_fill(input int k);
    return int'(fill[k*CW +: CW]);
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // one cycle: drive at negedge, check combinational read result, settle after edge
  task automatic step(input logic [N-1:0] mask, input bit rd, input bit exp_rv,
                      input bit acc, input string req);
    int bad;
    @(negedge clk);
    realign = 1'b0;
    rd_en = rd;
    wr_valid = mask;
    for (int k = 0; k < N; k++) wr_data[k*W +: W] = {4'(k), 12'(wr_seq[k])};
    #1;
    if (rd) begin
      check(rd_valid == exp_rv, req, "rd_valid", int'(rd_valid), int'(exp_rv));
      if (exp_rv && rd_valid) begin
        bad = 0;
        for (int k = 0; k < N; k++)
          if (rd_data[k*W +: W] != {4'(k), 12'(rd_seq[k])}) bad++;
        check(bad == 0, req, "lanes with wrong word", bad, 0);
      end
    end
    @(posedge clk);
    #1;
    for (int k = 0; k < N; k++) begin
      if (acc && mask[k]) wr_seq[k]++;
      if (rd && exp_rv) rd_seq[k]++;
    end
  endtask

  task automatic idle();
    step('0, 1'b0, 1'b0, 1'b0, "");
  endtask

  task automatic do_realign(input bit s);
    @(negedge clk);
    realign = 1'b1;
    shallow = s;
    wr_valid = '1;
    rd_en = 1'b1;
    @(posedge clk);
    #1;
    for (int k = 0; k < N; k++) begin
      wr_seq[k] = 0;
      rd_seq[k] = 0;
    end
  endtask

  task automatic t_reset();
    int nz = 0;
    for (int k = 0; k < N; k++) if (lane_fill(k) != 0) nz++;
    check(nz == 0, "R1", "nonzero fills", nz, 0);
    check(!running, "R1", "running", int'(running), 0);
    check(!slip, "R1", "slip", int'(slip), 0);
    check(!rd_valid, "R1", "rd_valid", int'(rd_valid), 0);
  endtask

  // staggered arrival: lane k starts k cycles late
  task automatic t_prefill_deep();
    logic [N-1:0] m;
    for (int c = 0; c < 25; c++) begin
      m = '0;
      for (int k = 0; k < N; k++) m[k] = (c >= k) && (c < k + 16);
      step(m, c == 10, 1'b0, 1'b1, "R2");
      if (c == 20) check(!running, "R2", "running before last lane", int'(running), 0);
    end
    check(lane_fill(9) == 16, "R10", "lane9 fill", lane_fill(9), 16);
    check(!running, "R2", "running at last write edge", int'(running), 0);
    idle();
    check(running, "R2", "running after target", int'(running), 1);
  endtask

  task automatic t_wander();
    for (int c = 0; c < 12; c++)
      step((c < 6) ? ~10'b0000001000 : '1, 1'b1, 1'b1, 1'b1, "R3");
    check(lane_fill(3) == 10, "R10", "lagging lane fill", lane_fill(3), 10);
    check(lane_fill(0) == 16, "R10", "lane0 fill", lane_fill(0), 16);
    for (int c = 0; c < 6; c++) step(10'b0000001000, 1'b0, 1'b0, 1'b1, "R4");
    for (int c = 0; c < 8; c++) step('1, 1'b1, 1'b1, 1'b1, "R3");
    for (int c = 0; c < 5; c++) step(10'b0000100000, 1'b0, 1'b0, 1'b1, "R4");
    check(lane_fill(5) == 21, "R10", "leading lane fill", lane_fill(5), 21);
    for (int c = 0; c < 5; c++) step(~10'b0000100000, 1'b1, 1'b1, 1'b1, "R4");
    check(lane_fill(5) == 16, "R4", "lane5 rebalanced", lane_fill(5), 16);
    check(!slip, "R4", "slip after wander", int'(slip), 0);
  endtask

  task automatic t_underflow();
    int f0;
    for (int c = 0; c < 16; c++) step(~10'b0000000100, 1'b1, 1'b1, 1'b1, "R3");
    check(lane_fill(2) == 0, "R10", "drained lane fill", lane_fill(2), 0);
    step('0, 1'b1, 1'b0, 1'b0, "R5");
    check(slip, "R5", "slip after underflow", int'(slip), 1);
    check(!running, "R5", "running after underflow", int'(running), 0);
    check(lane_fill(0) == 16, "R5", "no pop on underflow", lane_fill(0), 16);
    f0 = lane_fill(0);
    for (int c = 0; c < 3; c++) step('1, 1'b1, 1'b0, 1'b0, "R7");
    check(lane_fill(0) == f0, "R7", "lane0 fill frozen", lane_fill(0), f0);
    check(lane_fill(2) == 0, "R7", "lane2 fill frozen", lane_fill(2), 0);
    check(slip, "R7", "slip sticky", int'(slip), 1);
  endtask

  task automatic t_shallow();
    int nz = 0;
    do_realign(1'b1);
    for (int k = 0; k < N; k++) if (lane_fill(k) != 0) nz++;
    check(nz == 0, "R8", "fills after realign", nz, 0);
    check(!slip, "R8", "slip cleared", int'(slip), 0);
    check(!running, "R8", "running cleared", int'(running), 0);
    for (int c = 0; c < 4; c++) step('1, 1'b0, 1'b0, 1'b1, "R9");
    check(!running, "R9", "running at shallow target edge", int'(running), 0);
    idle();
    check(running, "R9", "running at shallow target", int'(running), 1);
    for (int c = 0; c < 6; c++) step('1, 1'b1, 1'b1, 1'b1, "R3");
    shallow = 1'b0;
    for (int c = 0; c < 4; c++) step(10'b0000000001, 1'b0, 1'b0, 1'b1, "R9");
    check(lane_fill(0) == 8, "R9", "lane0 at shallow depth", lane_fill(0), 8);
    check(!slip, "R9", "no slip at depth", int'(slip), 0);
    step(10'b0000000001, 1'b0, 1'b0, 1'b0, "R6");
    check(slip, "R6", "slip on overflow", int'(slip), 1);
    check(lane_fill(0) == 8, "R6", "overflow word dropped", lane_fill(0), 8);
    check(!running, "R6", "reading stopped", int'(running), 0);
  endtask

  task automatic t_deep_again();
    do_realign(1'b0);
    for (int c = 0; c < 4; c++) step('1, 1'b0, 1'b0, 1'b1, "R9");
    idle();
    idle();
    check(!running, "R9", "deep needs 16", int'(running), 0);
    for (int c = 0; c < 12; c++) step('1, 1'b0, 1'b0, 1'b1, "R9");
    idle();
    check(running, "R9", "deep start at 16", int'(running), 1);
    for (int c = 0; c < 20; c++) step('1, 1'b1, 1'b1, 1'b1, "R3");
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int k = 0; k < N; k++) begin
      wr_seq[k] = 0;
      rd_seq[k] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_prefill_deep();
    t_wander();
    t_underflow();
    t_shallow();
    t_deep_again();
    summary();
  end
endmodule